// File: doc/BRIEF.md
# Multi-Mode Bus Transfer Cycle Sequencer

This block is a bus master's cycle engine. It moves a block of sequential words from a local requester onto a shared bus that has an address lane and a data lane. A single start pulse carries a start address, a word count, a cycle style and a transfer width. The engine then produces the phases on the bus: an address phase, an optional wait phase and a data phase for each word, or one address phase followed by back-to-back data beats when streaming is allowed. Every phase length is a parameter counted in clock ticks.

Streaming is used only when both the requester and the target say they support it. Otherwise the engine falls back to per-word cycles. The 64-bit streaming styles carry the upper half of each 64-bit word on the address lane, and they also need the dual-path capability input. When that input is low, the request is degraded to 32-bit streaming and a one-cycle error flag is raised.

The engine fetches each word from `wdata_i` at the clock edge that opens a data phase, and it signals this with a one-cycle `take_o` pulse. The requester then presents the next word.

Top module: `xfer_seq`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `busy_o`, `done_o`, `err_o`, `take_o`, `addr_valid_o`, `data_valid_o` and `wait_o` are 0, and both bus lanes are 0.
- R2: For mode code 0, and for the unused codes 6 and 7, each word gets an address phase of BASIC_TICKS cycles followed by a data phase of BASIC_TICKS cycles. During the address phase `addr_valid_o` is 1 and the word address is on `bus_addr_o`. During the data phase `data_valid_o` is 1 and the word is on `bus_data_o`. At most one of `addr_valid_o`, `data_valid_o` and `wait_o` is high at a time.
- R3: `wide_i`=1 selects 32-bit words: the address steps by 4 per word and the data lane carries `wdata_i[31:0]`. `wide_i`=0 selects 16-bit words: the address steps by 2 and the data lane carries `wdata_i[15:0]` with its upper 16 bits zero.
- R4: Mode code 1 runs, for each word, an address phase, a wait phase (`wait_o`=1, both lanes 0) and a data phase, each MM_TICKS cycles long.
- R5: Mode code 2 runs, for each word, an address phase and a data phase, each MM_TICKS cycles long.
- R6: Mode code 3, with `req_stream_i` and `tgt_stream_i` both 1, runs one address phase of BASIC_TICKS cycles and then one data beat per word of BASIC_TICKS cycles each, back to back. During the beats `bus_addr_o` is 0.
- R7: Mode codes 3, 4 and 5 fall back to the per-word cycles of R2 when either streaming-support input is 0. Codes 4 and 5 then always use the 32-bit width.
- R8: Mode code 4, with both streaming-support inputs and `dual_path_i` at 1, runs one address phase and then BASIC_TICKS-cycle beats. Each beat puts `wdata_i[63:32]` on `bus_addr_o` and `wdata_i[31:0]` on `bus_data_o`.
- R9: Mode code 5, under the same conditions as R8, uses the same lane layout but with FAST_TICKS cycles for the address phase and for every beat.
- R10: Mode codes 4 and 5 with `dual_path_i`=0 raise `err_o` for exactly the first cycle after the start. The transfer then runs as 32-bit streaming at BASIC_TICKS, or as the per-word fallback if streaming is not supported.
- R11: `busy_o` is 1 from the cycle after an accepted start through the last data cycle. In the cycle after that, `done_o` is 1 for one cycle while `busy_o` is 0. A word count of 0 gives `done_o` in the next cycle with no bus phases.
- R12: A start pulse while `busy_o` is 1 is ignored. The running transfer continues unchanged.
- R13: `take_o` is 1 in the first cycle of each data phase or beat. The word on the bus is the value `wdata_i` held at the clock edge that opened that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 3 | Cycle style code (0 basic, 1 matched with wait, 2 matched without wait, 3 stream, 4 stream 64, 5 fast stream 64) |
| wide_i | input | 1 | 1 = 32-bit words, 0 = 16-bit words |
| start_addr_i | input | BUS_W | First word address |
| count_i | input | CNT_W | Number of words |
| req_stream_i | input | 1 | Requester supports streaming |
| tgt_stream_i | input | 1 | Target supports streaming |
| dual_path_i | input | 1 | Dual-path capability present |
| wdata_i | input | 2*BUS_W | Current word to send |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse: 64-bit stream degraded |
| take_o | output | 1 | Word on wdata_i consumed |
| addr_valid_o | output | 1 | Address phase active |
| data_valid_o | output | 1 | Data phase or beat active |
| wait_o | output | 1 | Wait phase active |
| bus_addr_o | output | BUS_W | Address lane |
| bus_data_o | output | BUS_W | Data lane |

## Verification
The hardest situation to reach is a start pulse that lands in the middle of a running transfer while carrying different mode, width and address values. The bench raises such a pulse a few cycles into a per-word transfer. The per-cycle reference model is left untouched, so any disturbance shows up as a mismatch. The degraded 64-bit cases need specific combinations of the three capability inputs. The bench walks through them, including the case where the fast 64-bit request loses both streaming and dual-path support at once and has to end up in plain 32-bit per-word cycles.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_WAIT = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    localparam logic [2:0] MD_BASIC         = 3'd0;
    localparam logic [2:0] MD_MM_WAIT       = 3'd1;
    localparam logic [2:0] MD_MM_NOWAIT     = 3'd2;
    localparam logic [2:0] MD_STREAM        = 3'd3;
    localparam logic [2:0] MD_STREAM64      = 3'd4;
    localparam logic [2:0] MD_STREAM64_FAST = 3'd5;

    localparam logic [1:0] LEN_BASIC = 2'd0;
    localparam logic [1:0] LEN_MM    = 2'd1;
    localparam logic [1:0] LEN_FAST  = 2'd2;

    typedef struct packed {
        logic       wait_en;
        logic       stream;
        logic       lane64;
        logic       wide;
        logic [1:0] len_sel;
        logic       err;
    } plan_t;

endpackage

// File: rtl/xfer_seq_plan.sv
module xfer_seq_plan
    import xfer_seq_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       wide_i,
    input  logic       req_stream_i,
    input  logic       tgt_stream_i,
    input  logic       dual_path_i,
    output plan_t      plan_o
);

    logic stream_ok;
    logic is64;

    always_comb begin
        stream_ok      = req_stream_i & tgt_stream_i;
        is64           = (mode_i == MD_STREAM64) || (mode_i == MD_STREAM64_FAST);
        plan_o         = '0;
        plan_o.wide    = wide_i | is64;
        plan_o.err     = is64 & ~dual_path_i;
        plan_o.len_sel = LEN_BASIC;
        case (mode_i)
            MD_MM_WAIT: begin
                plan_o.wait_en = 1'b1;
                plan_o.len_sel = LEN_MM;
            end
            MD_MM_NOWAIT: plan_o.len_sel = LEN_MM;
            MD_STREAM:    plan_o.stream  = stream_ok;
            MD_STREAM64: begin
                plan_o.stream = stream_ok;
                plan_o.lane64 = stream_ok & dual_path_i;
            end
            MD_STREAM64_FAST: begin
                plan_o.stream = stream_ok;
                plan_o.lane64 = stream_ok & dual_path_i;
                if (stream_ok && dual_path_i) plan_o.len_sel = LEN_FAST;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xfer_seq_lanes.sv
module xfer_seq_lanes
    import xfer_seq_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  phase_e                 phase_i,
    input  logic [BUS_W-1:0]       addr_i,
    input  logic [2*BUS_W-1:0]     word_i,
    input  logic                   lane64_i,
    input  logic                   wide_i,
    output logic [BUS_W-1:0]       bus_addr_o,
    output logic [BUS_W-1:0]       bus_data_o,
    output logic                   addr_valid_o,
    output logic                   data_valid_o,
    output logic                   wait_o
);

    localparam int HALF = BUS_W / 2;

    always_comb begin
        bus_addr_o   = '0;
        bus_data_o   = '0;
        addr_valid_o = 1'b0;
        data_valid_o = 1'b0;
        wait_o       = 1'b0;
        case (phase_i)
            PH_ADDR: begin
                addr_valid_o = 1'b1;
                bus_addr_o   = addr_i;
            end
            PH_WAIT: wait_o = 1'b1;
            PH_DATA: begin
                data_valid_o = 1'b1;
                if (lane64_i) begin
                    bus_addr_o = word_i[2*BUS_W-1:BUS_W];
                    bus_data_o = word_i[BUS_W-1:0];
                end else if (wide_i) begin
                    bus_data_o = word_i[BUS_W-1:0];
                end else begin
                    bus_data_o = {{HALF{1'b0}}, word_i[HALF-1:0]};
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_seq_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int CNT_W       = 16,
    parameter int BASIC_TICKS = 8,
    parameter int MM_TICKS    = 5,
    parameter int FAST_TICKS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [2:0]           mode_i,
    input  logic                 wide_i,
    input  logic [BUS_W-1:0]     start_addr_i,
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 req_stream_i,
    input  logic                 tgt_stream_i,
    input  logic                 dual_path_i,
    input  logic [2*BUS_W-1:0]   wdata_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic                 take_o,
    output logic                 addr_valid_o,
    output logic                 data_valid_o,
    output logic                 wait_o,
    output logic [BUS_W-1:0]     bus_addr_o,
    output logic [BUS_W-1:0]     bus_data_o
);

    localparam int MAX_BM    = (BASIC_TICKS > MM_TICKS) ? BASIC_TICKS : MM_TICKS;
    localparam int MAX_TICKS = (MAX_BM > FAST_TICKS) ? MAX_BM : FAST_TICKS;
    localparam int TICK_W    = $clog2(MAX_TICKS + 1);
    localparam logic [BUS_W-1:0] STEP32 = BUS_W'(BUS_W / 8);
    localparam logic [BUS_W-1:0] STEP16 = BUS_W'(BUS_W / 16);

    typedef struct packed {
        phase_e               phase;
        logic [TICK_W-1:0]    ticks;
        logic [CNT_W-1:0]     left;
        logic [BUS_W-1:0]     addr;
        logic [2*BUS_W-1:0]   word;
        plan_t                plan;
        logic                 busy;
        logic                 done;
        logic                 err;
        logic                 take;
    } seq_t;

    seq_t  s_d, s_q;
    plan_t plan_w;
    logic  enter_data_d;

    function automatic logic [TICK_W-1:0] len_of(input logic [1:0] sel);
        case (sel)
            LEN_MM:   len_of = TICK_W'(MM_TICKS - 1);
            LEN_FAST: len_of = TICK_W'(FAST_TICKS - 1);
            default:  len_of = TICK_W'(BASIC_TICKS - 1);
        endcase
    endfunction

    xfer_seq_plan plan_i (
        .mode_i       (mode_i),
        .wide_i       (wide_i),
        .req_stream_i (req_stream_i),
        .tgt_stream_i (tgt_stream_i),
        .dual_path_i  (dual_path_i),
        .plan_o       (plan_w)
    );

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.err      = 1'b0;
        s_d.take     = 1'b0;
        enter_data_d = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start_i) begin
                s_d.plan = plan_w;
                s_d.err  = plan_w.err;
                if (count_i == '0) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.phase = PH_ADDR;
                    s_d.ticks = len_of(plan_w.len_sel);
                    s_d.left  = count_i;
                    s_d.addr  = start_addr_i;
                    s_d.busy  = 1'b1;
                end
            end
        end else if (s_q.ticks != '0) begin
            s_d.ticks = s_q.ticks - 1'b1;
        end else begin
            s_d.ticks = len_of(s_q.plan.len_sel);
            case (s_q.phase)
                PH_ADDR: begin
                    if (s_q.plan.wait_en) s_d.phase = PH_WAIT;
                    else                  enter_data_d = 1'b1;
                end
                PH_WAIT: enter_data_d = 1'b1;
                default: begin
                    if (s_q.left == CNT_W'(1)) begin
                        s_d.phase = PH_IDLE;
                        s_d.ticks = '0;
                        s_d.left  = '0;
                        s_d.busy  = 1'b0;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.left = s_q.left - 1'b1;
                        if (s_q.plan.stream) begin
                            enter_data_d = 1'b1;
                        end else begin
                            s_d.addr  = s_q.addr + (s_q.plan.wide ? STEP32 : STEP16);
                            s_d.phase = PH_ADDR;
                        end
                    end
                end
            endcase
        end
        if (enter_data_d) begin
            s_d.phase = PH_DATA;
            s_d.word  = wdata_i;
            s_d.take  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    xfer_seq_lanes #(.BUS_W(BUS_W)) lanes_i (
        .phase_i      (s_q.phase),
        .addr_i       (s_q.addr),
        .word_i       (s_q.word),
        .lane64_i     (s_q.plan.lane64),
        .wide_i       (s_q.plan.wide),
        .bus_addr_o   (bus_addr_o),
        .bus_data_o   (bus_data_o),
        .addr_valid_o (addr_valid_o),
        .data_valid_o (data_valid_o),
        .wait_o       (wait_o)
    );

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign err_o  = s_q.err;
    assign take_o = s_q.take;

    // R2
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_valid_o, data_valid_o, wait_o}));

    // R4
    wait_only_mm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> s_q.plan.wait_en);

    // R6
    stream_no_readdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_DATA && s_q.plan.stream && s_q.ticks == '0 && s_q.left != CNT_W'(1))
        |=> (take_o && !addr_valid_o));

    // R11
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R12
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(s_q.plan));

    // R13
    take_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> data_valid_o);

endmodule

// File: tb/xfer_seq_tb_top.sv
module xfer_seq_tb_top;

    localparam int BT = 8;
    localparam int MT = 5;
    localparam int FT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic        wide_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [15:0] count_i = '0;
    logic        req_stream_i = 1'b0;
    logic        tgt_stream_i = 1'b0;
    logic        dual_path_i = 1'b0;
    logic [63:0] wdata_i = '0;
    logic        busy_o, done_o, err_o, take_o;
    logic        addr_valid_o, data_valid_o, wait_o;
    logic [31:0] bus_addr_o, bus_data_o;

    always #5 clk = ~clk;

    xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .wide_i(wide_i),
        .start_addr_i(start_addr_i), .count_i(count_i), .req_stream_i(req_stream_i),
        .tgt_stream_i(tgt_stream_i), .dual_path_i(dual_path_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .take_o(take_o),
        .addr_valid_o(addr_valid_o), .data_valid_o(data_valid_o), .wait_o(wait_o),
        .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        av, dv, wt, tk, bz, dn, er;
        logic [31:0] ba, bd;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   seed   = 0;
    int   take_k = 0;
    bit   running = 1'b0;
    bit   err_pend = 1'b0;
    int   cyc = 0;

    function automatic logic [63:0] word_of(input int s, input int k);
        logic [31:0] hi, lo;
        hi = 32'h5A00_0000 ^ (32'(s) << 16) ^ 32'(k);
        lo = 32'hA500_0000 + (32'(s) << 8) + 32'(k * 7) + 32'h0001_1000;
        return {hi, lo};
    endfunction

    task automatic push_phase(input int n, input logic av, input logic dv, input logic wt,
                              input logic [31:0] ba, input logic [31:0] bd, input int rq);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e = '0;
            e.req = 8'(rq);
            e.av = av; e.dv = dv; e.wt = wt;
            e.tk = dv && (i == 0);
            e.bz = 1'b1;
            e.er = err_pend;
            err_pend = 1'b0;
            e.ba = ba; e.bd = bd;
            exp_q.push_back(e);
        end
    endtask

    // Reference model: builds the expected per-cycle output stream for one transfer.
    task automatic model(input int rq, input logic [2:0] md, input logic wd, input logic rs,
                         input logic ts, input logic dp, input logic [31:0] a, input int n);
        bit ok, is64, use_w, strm, l64, wt_en;
        int t;
        exp_t e;
        ok    = rs && ts;
        is64  = (md == 3'd4) || (md == 3'd5);
        use_w = wd || is64;
        err_pend = is64 && !dp;
        strm  = 1'b0; l64 = 1'b0; wt_en = 1'b0; t = BT;
        case (md)
            3'd1: begin wt_en = 1'b1; t = MT; end
            3'd2: t = MT;
            3'd3: strm = ok;
            3'd4: begin strm = ok; l64 = ok && dp; end
            3'd5: begin strm = ok; l64 = ok && dp; if (ok && dp) t = FT; end
            default: ;
        endcase
        if (n > 0) begin
            if (strm) begin
                push_phase(t, 1'b1, 1'b0, 1'b0, a, 32'h0, rq);
                for (int k = 0; k < n; k++) begin
                    logic [63:0] w;
                    w = word_of(seed, k);
                    if (l64)        push_phase(t, 1'b0, 1'b1, 1'b0, w[63:32], w[31:0], rq);
                    else if (use_w) push_phase(t, 1'b0, 1'b1, 1'b0, 32'h0, w[31:0], rq);
                    else            push_phase(t, 1'b0, 1'b1, 1'b0, 32'h0, {16'h0, w[15:0]}, rq);
                end
            end else begin
                for (int k = 0; k < n; k++) begin
                    logic [63:0] w;
                    logic [31:0] wa;
                    w  = word_of(seed, k);
                    wa = a + 32'(k * (use_w ? 4 : 2));
                    push_phase(t, 1'b1, 1'b0, 1'b0, wa, 32'h0, rq);
                    if (wt_en) push_phase(t, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, rq);
                    push_phase(t, 1'b0, 1'b1, 1'b0, 32'h0,
                               use_w ? w[31:0] : {16'h0, w[15:0]}, rq);
                end
            end
        end
        e = '0;
        e.req = 8'(rq);
        e.dn = 1'b1;
        e.er = err_pend;
        err_pend = 1'b0;
        exp_q.push_back(e);
    endtask

    task automatic run(input int rq, input logic [2:0] md, input logic wd, input logic rs,
                       input logic ts, input logic dp, input logic [31:0] a, input int n,
                       input bit drain);
        @(negedge clk); #1;
        seed++;
        take_k = 0;
        wdata_i = word_of(seed, 0);
        mode_i = md; wide_i = wd; req_stream_i = rs; tgt_stream_i = ts;
        dual_path_i = dp; start_addr_i = a; count_i = 16'(n);
        start_i = 1'b1;
        model(rq, md, wd, rs, ts, dp, a, n);
        @(negedge clk); #1;
        start_i = 1'b0;
        if (drain) begin
            while (exp_q.size() > 0) @(negedge clk);
            repeat (3) @(negedge clk);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            exp_t e;
            logic [70:0] act, ex;
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else begin e = '0; e.req = 8'd1; end   // R1 idle outputs
            act = {addr_valid_o, data_valid_o, wait_o, take_o, busy_o, done_o, err_o,
                   bus_addr_o, bus_data_o};
            ex  = {e.av, e.dv, e.wt, e.tk, e.bz, e.dn, e.er, e.ba, e.bd};
            checks++;
            if (act !== ex) begin
                fails++;
                $display("FAIL R%0d cycle %0d: actual %h expected %h", e.req, cyc, act, ex);
            end
            if (take_o) begin
                take_k++;
                wdata_i = word_of(seed, take_k);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while held in reset
        checks++;
        if ({busy_o, done_o, err_o, take_o, addr_valid_o, data_valid_o, wait_o,
             bus_addr_o, bus_data_o} !== '0) begin
            fails++;
            $display("FAIL R1 reset: actual %b%b%b%b %h %h expected 0", busy_o, done_o, err_o,
                     take_o, bus_addr_o, bus_data_o);
        end
        #1 rst_n = 1'b1;
        running = 1'b1;
        repeat (2) @(negedge clk);

        run(2,  3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 3, 1'b1); // R2 basic 32-bit
        run(3,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_2002, 2, 1'b1); // R3 16-bit step 2
        run(2,  3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_3000, 1, 1'b1); // R2 unused code
        run(4,  3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_4000, 2, 1'b1); // R4 wait phase
        run(5,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_5000, 2, 1'b1); // R5 no wait
        run(6,  3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_6000, 4, 1'b1); // R6 stream 32
        run(6,  3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_6100, 3, 1'b1); // R6 stream 16
        run(7,  3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_7000, 2, 1'b1); // R7 target lacks stream
        run(8,  3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_8000, 3, 1'b1); // R8 64-bit lanes
        run(10, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_A000, 2, 1'b1); // R10 degrade + err
        run(9,  3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_9000, 3, 1'b1); // R9 fast beats
        run(10, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_A100, 2, 1'b1); // R10 fast degrade
        run(7,  3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_7100, 2, 1'b1); // R7 fast, no stream
        run(10, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_A200, 1, 1'b1); // R10 both missing
        run(11, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_B000, 0, 1'b1); // R11 zero count
        run(13, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_D000, 3, 1'b1); // R13 word capture

        // R12: start pulse mid-transfer with other settings must be ignored
        run(12, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_C000, 2, 1'b0);
        repeat (5) @(negedge clk);
        #1;
        mode_i = 3'd5; wide_i = 1'b0; req_stream_i = 1'b1; tgt_stream_i = 1'b1;
        dual_path_i = 1'b0; start_addr_i = 32'hFFFF_0000; count_i = 16'd9;
        start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);

        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule